// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Wake Filter

This block receives asynchronous serial characters on a single input line. A separate baud generator supplies a one-cycle tick at sixteen times the bit rate. A falling edge on the idle-high line starts a character. The receiver confirms the start bit at mid-bit and then samples each following bit at the centre of its period. A character is eight data bits, least significant bit first, then an optional even-parity bit and one stop bit.

When a character completes, it moves from the shift register into a holding buffer. At the same time a ready flag and an interrupt request are raised, and framing, parity and overrun status is latched. In multidrop systems a wake filter can be enabled: it discards every character whose top bit is clear, so only address characters reach the buffer. An invert option presents the complement of the buffer at the read port. A request-to-send style output tells the transmitter when the receiver cannot take more data.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, `rdy`, `irq`, `frame_err`, `parity_err` and `overrun` are 0, and `rts` is 0 while `rx_en` is 1.
- R2: Reception starts only on a high-to-low transition of `rxd` while `rx_en` is 1. With `rx_en` at 0, a complete character leaves `rdy` at 0 and the buffer unchanged, and `rts` is 1.
- R3: A low pulse shorter than half a bit period is not a start bit. It produces no character and no flag, and `rts` returns to 0.
- R4: Data bits arrive least significant bit first. Bit i of `rd_data` (with invert off) equals the i-th data bit after the start bit. When the stop bit is sampled, the character is stored and `rdy` and `irq` go to 1.
- R5: With `parity_en` at 1, a ninth bit follows D7. An even count of ones across D0..D7 plus this bit is correct. A wrong count sets `parity_err` for that character; a correct count clears it.
- R6: A stop bit sampled low sets `frame_err`, and the character is still stored. A high stop bit clears `frame_err`.
- R7: `irq` clears on a pulse on `irq_ack` or on `irq_clr`.
- R8: A pulse on `rd_stb` clears `rdy` and `overrun`. If a character is stored while `rdy` is still 1, the new character replaces the old one and `overrun` goes to 1.
- R9: With `sleep_en` at 1, a character whose bit 7 is 0 is discarded. It changes neither the buffer, `rdy`, `irq` nor the error flags. A character whose bit 7 is 1 is accepted normally.
- R10: With `invert_en` at 1, `rd_data` is the bitwise complement of the stored character; with 0 it is the stored character.
- R11: `rts` is 1 from start-bit detection until the buffer has been read, and 0 when the receiver is idle, enabled and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| parity_en | input | 1 | Expect an even-parity bit |
| sleep_en | input | 1 | Discard characters with bit 7 clear |
| invert_en | input | 1 | Complement data at the read port |
| rd_stb | input | 1 | Buffer read pulse |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_clr | input | 1 | Software clear of the interrupt request |
| rd_data | output | 8 | Buffer contents, optionally complemented |
| rdy | output | 1 | Receive-complete flag |
| irq | output | 1 | Receive interrupt request |
| frame_err | output | 1 | Stop bit of last stored character was low |
| parity_err | output | 1 | Parity of last stored character was wrong |
| overrun | output | 1 | A stored character was overwritten unread |
| rts | output | 1 | High when the receiver cannot accept data |

## Verification
A character is stored one clock after the tick that samples the middle of its stop bit. The line passes through a two-stage synchronizer first, so this point falls about half a bit, plus three clocks, into the stop bit. Every check that follows a frame therefore waits until the full stop bit has been driven and the line has returned high. The results have then been stable for several ticks. Flag clears from `rd_stb`, `irq_ack` and `irq_clr` are due one clock after the pulse, and `rd_data` follows `invert_en` in the same cycle. The bench samples these on the next falling edge. The `rts` state during a frame is checked well after the start bit has been confirmed, and again once the frame is over.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OVS    = 16;
    localparam int unsigned CNT_W  = $clog2(OVS);
    localparam int unsigned BIT_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_char_t;

    function automatic logic even_par_bad(input logic [DATA_W-1:0] d, input logic pbit);
        return (^d) ^ pbit;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxs,
    input  logic     rx_en,
    input  logic     parity_en,
    output logic     busy,
    output logic     done,
    output rx_char_t chr
);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] TOPB = BIT_W'(DATA_W - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              pbit_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            pbit_q  <= 1'b0;
            prev_q  <= 1'b1;
            chr     <= '0;
        end else if (!rx_en) begin
            state_q <= RX_IDLE;
            if (tick) prev_q <= rxs;
        end else if (tick) begin
            prev_q <= rxs;
            cnt_q  <= cnt_q + 1'b1;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (prev_q && !rxs) state_q <= RX_START;
                end
                RX_START: begin
                    if (cnt_q == MID) begin
                        cnt_q   <= '0;
                        bit_q   <= '0;
                        state_q <= rxs ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == LAST) begin
                        shreg_q <= {rxs, shreg_q[DATA_W-1:1]};
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == TOPB) state_q <= parity_en ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (cnt_q == LAST) begin
                        pbit_q  <= rxs;
                        state_q <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == LAST) begin
                        chr.data <= shreg_q;
                        chr.ferr <= !rxs;
                        chr.perr <= parity_en && even_par_bad(shreg_q, pbit_q);
                        done     <= 1'b1;
                        state_q  <= RX_IDLE;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign busy = (state_q != RX_IDLE);

    // R3
    start_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && tick && state_q == RX_START && cnt_q == MID && rxs) |=> (state_q == RX_IDLE && !done));

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (state_q == RX_IDLE));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          chr,
    input  logic              busy,
    input  logic              rx_en,
    input  logic              sleep_en,
    input  logic              invert_en,
    input  logic              rd_stb,
    input  logic              irq_ack,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              irq,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun,
    output logic              rts
);
    logic [DATA_W-1:0] buf_q;
    logic              accept;

    assign accept = done && (!sleep_en || chr.data[DATA_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q      <= '0;
            rdy        <= 1'b0;
            irq        <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (rd_stb) begin
                rdy     <= 1'b0;
                overrun <= 1'b0;
            end
            if (irq_ack || irq_clr) irq <= 1'b0;
            if (accept) begin
                buf_q      <= chr.data;
                rdy        <= 1'b1;
                irq        <= 1'b1;
                frame_err  <= chr.ferr;
                parity_err <= chr.perr;
                overrun    <= rdy && !rd_stb;
            end
        end
    end

    assign rd_data = invert_en ? ~buf_q : buf_q;
    assign rts     = !rx_en || busy || rdy;

    // R4
    store_flags_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (rdy && irq && buf_q == $past(chr.data)));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !accept) |=> (!rdy && !overrun));

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_ack || irq_clr) && !accept) |=> !irq);

    // R9
    sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (done && sleep_en && !chr.data[DATA_W-1] && !rd_stb && !irq_ack && !irq_clr)
            |=> ($stable(buf_q) && $stable(rdy) && $stable(irq) && $stable(frame_err)));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              parity_en,
    input  logic              sleep_en,
    input  logic              invert_en,
    input  logic              rd_stb,
    input  logic              irq_ack,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              irq,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun,
    output logic              rts
);
    logic     rxs;
    logic     busy;
    logic     done;
    rx_char_t chr;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(rxs)
    );

    uart_rx_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rxs      (rxs),
        .rx_en    (rx_en),
        .parity_en(parity_en),
        .busy     (busy),
        .done     (done),
        .chr      (chr)
    );

    uart_rx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .chr       (chr),
        .busy      (busy),
        .rx_en     (rx_en),
        .sleep_en  (sleep_en),
        .invert_en (invert_en),
        .rd_stb    (rd_stb),
        .irq_ack   (irq_ack),
        .irq_clr   (irq_clr),
        .rd_data   (rd_data),
        .rdy       (rdy),
        .irq       (irq),
        .frame_err (frame_err),
        .parity_err(parity_err),
        .overrun   (overrun),
        .rts       (rts)
    );

    // R11
    rts_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> rts);
endmodule

// File: tb/tb_uart_wake_rx.sv
module tb_uart_wake_rx;
    localparam int TICK_DIV = 4;
    localparam int BITCLK   = 16 * TICK_DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick;
    logic rxd = 1'b1;
    logic rx_en = 1'b1, parity_en = 1'b0, sleep_en = 1'b0, invert_en = 1'b0;
    logic rd_stb = 1'b0, irq_ack = 1'b0, irq_clr = 1'b0;
    logic [7:0] rd_data;
    logic rdy, irq, frame_err, parity_err, overrun, rts;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
    assign tick = (tcnt == TICK_DIV - 1);

    uart_wake_rx dut (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_en(rx_en),
        .parity_en(parity_en), .sleep_en(sleep_en), .invert_en(invert_en),
        .rd_stb(rd_stb), .irq_ack(irq_ack), .irq_clr(irq_clr),
        .rd_data(rd_data), .rdy(rdy), .irq(irq), .frame_err(frame_err),
        .parity_err(parity_err), .overrun(overrun), .rts(rts)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic par_on, input logic pbit, input logic stopv);
        @(negedge clk);
        hold_line(1'b0, BITCLK);
        for (int i = 0; i < 8; i++) hold_line(d[i], BITCLK);
        if (par_on) hold_line(pbit, BITCLK);
        hold_line(stopv, BITCLK);
        hold_line(1'b1, BITCLK / 2);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 rdy", {7'd0, rdy}, 8'd0);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 errs", {5'd0, frame_err, parity_err, overrun}, 8'd0);
        chk("R1 rts", {7'd0, rts}, 8'd0);
    endtask

    task automatic t_basic();
        send(8'hA5, 1'b0, 1'b0, 1'b1);
        chk("R4 data", rd_data, 8'hA5);
        chk("R4 rdy", {7'd0, rdy}, 8'd1);
        chk("R4 irq", {7'd0, irq}, 8'd1);
        chk("R11 rts while unread", {7'd0, rts}, 8'd1);
        pulse_rd();
        chk("R8 rdy cleared", {7'd0, rdy}, 8'd0);
        chk("R11 rts after read", {7'd0, rts}, 8'd0);
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
        chk("R7 irq ack", {7'd0, irq}, 8'd0);
        send(8'h01, 1'b0, 1'b0, 1'b1);
        chk("R4 lsb first", rd_data, 8'h01);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk("R7 irq clr", {7'd0, irq}, 8'd0);
        pulse_rd();
    endtask

    task automatic t_rts_mid();
        fork
            send(8'h3C, 1'b0, 1'b0, 1'b1);
            begin
                repeat (BITCLK * 3) @(negedge clk);
                chk("R11 rts during frame", {7'd0, rts}, 8'd1);
            end
        join
        chk("R4 data 3C", rd_data, 8'h3C);
        pulse_rd();
    endtask

    task automatic t_parity();
        parity_en = 1'b1;
        send(8'h37, 1'b1, ^8'h37, 1'b1);
        chk("R5 good parity data", rd_data, 8'h37);
        chk("R5 good parity flag", {7'd0, parity_err}, 8'd0);
        pulse_rd();
        send(8'h37, 1'b1, ~(^8'h37), 1'b1);
        chk("R5 bad parity flag", {7'd0, parity_err}, 8'd1);
        pulse_rd();
        send(8'h81, 1'b1, ^8'h81, 1'b1);
        chk("R5 parity cleared", {7'd0, parity_err}, 8'd0);
        pulse_rd();
        parity_en = 1'b0;
    endtask

    task automatic t_frame();
        send(8'h5A, 1'b0, 1'b0, 1'b0);
        chk("R6 frame err", {7'd0, frame_err}, 8'd1);
        chk("R6 data kept", rd_data, 8'h5A);
        pulse_rd();
        send(8'h66, 1'b0, 1'b0, 1'b1);
        chk("R6 frame err cleared", {7'd0, frame_err}, 8'd0);
        pulse_rd();
    endtask

    task automatic t_overrun();
        send(8'h11, 1'b0, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        chk("R8 overrun", {7'd0, overrun}, 8'd1);
        chk("R8 newest kept", rd_data, 8'h22);
        pulse_rd();
        chk("R8 overrun cleared", {7'd0, overrun}, 8'd0);
    endtask

    task automatic t_sleep();
        sleep_en = 1'b1;
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        send(8'h35, 1'b0, 1'b0, 1'b1);
        chk("R9 discard rdy", {7'd0, rdy}, 8'd0);
        chk("R9 discard irq", {7'd0, irq}, 8'd0);
        chk("R9 buffer kept", rd_data, 8'h22);
        send(8'h9C, 1'b0, 1'b0, 1'b1);
        chk("R9 accept rdy", {7'd0, rdy}, 8'd1);
        chk("R9 accept data", rd_data, 8'h9C);
        pulse_rd();
        sleep_en = 1'b0;
    endtask

    task automatic t_invert();
        @(negedge clk) invert_en = 1'b1;
        @(negedge clk);
        chk("R10 inverted", rd_data, 8'h63);
        invert_en = 1'b0;
        @(negedge clk);
        chk("R10 plain", rd_data, 8'h9C);
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        @(negedge clk);
        chk("R2 rts when disabled", {7'd0, rts}, 8'd1);
        send(8'h44, 1'b0, 1'b0, 1'b1);
        chk("R2 no char", {7'd0, rdy}, 8'd0);
        chk("R2 buffer kept", rd_data, 8'h9C);
        rx_en = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        hold_line(1'b0, 3 * TICK_DIV);
        hold_line(1'b1, 3 * BITCLK);
        chk("R3 glitch no rdy", {7'd0, rdy}, 8'd0);
        chk("R3 glitch rts", {7'd0, rts}, 8'd0);
        chk("R3 glitch buffer", rd_data, 8'h9C);
        send(8'hC3, 1'b0, 1'b0, 1'b1);
        chk("R3 next frame ok", rd_data, 8'hC3);
        pulse_rd();
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst = 1'b0;
                repeat (BITCLK) @(negedge clk);
                t_reset();
                t_basic();
                t_rts_mid();
                t_parity();
                t_frame();
                t_overrun();
                t_sleep();
                t_invert();
                t_disabled();
                t_glitch();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule